// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the always-on power controller of a microcontroller-class chip. It watches the processor's wait-for-interrupt and wait-for-event strobes, the lowest-priority handler return strobe and a handful of control bits. From these it moves the chip between four operating levels: Run, Sleep, Deep-sleep and Standby. The outputs drive the clock gates, the oscillator and PLL enables, the regulator mode and shutdown, the core-domain power switch, a clock-source override and a power-on-reset request.

Each low-power level has its own entry rule and its own wake rule. Sleep stops only the processor clock and wakes on a line interrupt or event. Deep-sleep stops every core-domain clock and all oscillators. It is refused while any external line is still pending. On exit it waits a parameterised settling time, longer when the regulator was in low-power mode, and forces the internal RC oscillator as the clock source. Standby removes core power. It is refused while the wake flag is set, and it is left only through a full power-on reset, started by the reset pin, an RTC alarm, a watchdog reset or a rising edge on the wake pin. Two sticky flags record that Standby was entered and that the wake pin rose. Both flags sit in the always-on domain and survive the reset that ends Standby.

Top module: `lpm_seq`

## Requirements
- R1: After `rst_n` is released, `mode` is 0 (Run), all clock and oscillator enables are 1, `core_pwr_on` is 1, and `reg_lp`, `reg_off`, `clk_sel_rc`, `por_req`, `stby_flag` and `wake_flag` are 0.
- R2: With `deep_sel`=0 and `exit_sleep_sel`=0, a `wfi_req` or `wfe_req` strobe in Run gives `mode`=1 (Sleep) at the next clock edge. In Sleep, `cpu_clk_en` is 0 while `bus_clk_en` and all oscillator enables stay 1. An `isr_exit` strobe in this setting has no effect.
- R3: With `exit_sleep_sel`=1 and `deep_sel`=0, `wfi_req` and `wfe_req` leave the block in Run, and an `isr_exit` strobe enters Sleep. That Sleep follows the wait-for-interrupt wake rule.
- R4: A Sleep or Deep-sleep entered by `wfi_req` (or by `isr_exit`) wakes on any bit of `line_irq`. One entered by `wfe_req` alone wakes on any bit of `line_evt`, and also on any bit of `line_irq` when `sev_pend_sel`=1. No other input wakes it. Waking from Sleep returns to Run at the next edge.
- R5: With `deep_sel`=1, `stby_sel`=0 and no `line_pend` bit set, a request gives `mode`=2. In that state every clock and oscillator enable is 0, `core_pwr_on` is 1, `reg_off` is 0, and `reg_lp` holds the value `lp_reg_sel` had when the request was taken.
- R6: After a Deep-sleep wake, `mode` stays 2 with clocks gated, `rcosc_en`=1, `xtal_en`=`pll_en`=0, `reg_lp`=0 and `clk_sel_rc`=1. This lasts EXIT_NORM+1 cycles, or EXIT_LP+1 cycles when `reg_lp` was 1. The block then returns to Run with `clk_sel_rc`=0.
- R7: If any `line_pend` bit is set when a Deep-sleep request arrives, the request is dropped and every output keeps its Run value.
- R8: With `deep_sel`=1, `stby_sel`=1 and `wake_flag`=0, a request gives `mode`=3. In that state `stby_flag` is 1, `core_pwr_on` is 0, `reg_off` is 1, and all clock and oscillator enables are 0. While `wake_flag`=1, the same request leaves the block in Run.
- R9: Standby is left only on `ext_rst`, `rtc_alarm`, `wdog_rst` or a wake-pin rising edge. Line interrupts and events do not wake it. A wake starts a reset hold of POR_HOLD+1 cycles with `mode`=3, `por_req`=1, `core_pwr_on`=1, `reg_off`=0, `rcosc_en`=1, `clk_sel_rc`=1 and clocks gated. The block then returns to Run.
- R10: `wake_pin` passes through a two-flop synchronizer. A 0-to-1 change sets `wake_flag` at the third clock edge after it, and in Standby it starts the reset hold at that same edge. A pin held high causes no further wake.
- R11: `stby_flag` and `wake_flag` are sticky. A one-cycle `clr_stby` or `clr_wake` strobe clears the matching flag, and a set in the same cycle wins. `stby_flag` stays 1 through the reset hold and into Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the always-on domain |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the processor |
| wfe_req | input | 1 | Wait-for-event strobe from the processor |
| isr_exit | input | 1 | Strobe on return from the lowest-priority handler |
| deep_sel | input | 1 | Selects a deep level (Deep-sleep or Standby) |
| stby_sel | input | 1 | With deep_sel, selects Standby over Deep-sleep |
| exit_sleep_sel | input | 1 | Sleep only on handler return |
| lp_reg_sel | input | 1 | Regulator low-power mode for Deep-sleep |
| sev_pend_sel | input | 1 | Lets line interrupts wake a wait-for-event |
| line_irq | input | LINES | External line interrupt requests |
| line_evt | input | LINES | External line events |
| line_pend | input | LINES | External line pending flags |
| ext_rst | input | 1 | Reset pin request (Standby wake) |
| rtc_alarm | input | 1 | RTC alarm (Standby wake) |
| wdog_rst | input | 1 | Watchdog reset (Standby wake) |
| wake_pin | input | 1 | Asynchronous wake pin |
| clr_stby | input | 1 | Write-1 clear of stby_flag |
| clr_wake | input | 1 | Write-1 clear of wake_flag |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | 1 | Core-domain bus and peripheral clock enable |
| rcosc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| reg_lp | output | 1 | Regulator low-power mode |
| reg_off | output | 1 | Regulator shutdown |
| core_pwr_on | output | 1 | Core-domain power switch |
| clk_sel_rc | output | 1 | Forces the system clock to the RC oscillator |
| por_req | output | 1 | Power-on-reset request to the core domain |
| mode | output | 2 | Level: 0 Run, 1 Sleep, 2 Deep-sleep, 3 Standby |
| stby_flag | output | 1 | Sticky: Standby was entered |
| wake_flag | output | 1 | Sticky: wake pin rose |

## Verification
Both wait strobes are tried at each level, and the handler-return strobe is tried with the sleep-on-exit bit both set and clear. This shows that the entry path is chosen by the select bits and not by which strobe arrives. Sleep and Deep-sleep are each offered the wrong kind of wake first (an event after a wait-for-interrupt, an interrupt after a wait-for-event with set-on-pending clear) and then the right one. This separates the two stored wake rules. Deep-sleep exit is traced cycle by cycle with the regulator bit clear and set, and this tells the two settling loads apart. Standby is woken from each of its four sources while line interrupts are offered in vain. The wake pin is held high across a Standby entry and then toggled, which separates edge detection from level detection.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_SLEEP = 3'd1,
      ST_DEEP  = 3'd2,
      ST_DEXIT = 3'd3,
      ST_STBY  = 3'd4,
      ST_PORH  = 3'd5
   } lpm_state_e;

   localparam logic [1:0] MODE_RUN   = 2'd0;
   localparam logic [1:0] MODE_SLEEP = 2'd1;
   localparam logic [1:0] MODE_DEEP  = 2'd2;
   localparam logic [1:0] MODE_STBY  = 2'd3;

   typedef struct packed {
      logic       cpu_clk;
      logic       bus_clk;
      logic       rcosc;
      logic       xtal;
      logic       pll;
      logic       reg_lp;
      logic       reg_off;
      logic       pwr_on;
      logic       sel_rc;
      logic       por;
      logic [1:0] mode;
   } lpm_out_t;

endpackage

// File: rtl/lpm_edge_sync.sv
module lpm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R10

endmodule

// File: rtl/lpm_dncnt.sv
module lpm_dncnt #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
   end

   assign zero = (cnt_q == '0);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R6

endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
   import lpm_pkg::*;
(
   input  lpm_state_e state,
   input  logic       lp_hold,
   output lpm_out_t   o
);

   always_comb begin
      o = '{cpu_clk: 1'b1, bus_clk: 1'b1, rcosc: 1'b1, xtal: 1'b1, pll: 1'b1,
            reg_lp: 1'b0, reg_off: 1'b0, pwr_on: 1'b1, sel_rc: 1'b0,
            por: 1'b0, mode: MODE_RUN};
      case (state)
         ST_SLEEP: begin
            o.cpu_clk = 1'b0;
            o.mode    = MODE_SLEEP;
         end
         ST_DEEP: begin
            o.cpu_clk = 1'b0;
            o.bus_clk = 1'b0;
            o.rcosc   = 1'b0;
            o.xtal    = 1'b0;
            o.pll     = 1'b0;
            o.reg_lp  = lp_hold;
            o.mode    = MODE_DEEP;
         end
         ST_DEXIT: begin
            o.cpu_clk = 1'b0;
            o.bus_clk = 1'b0;
            o.xtal    = 1'b0;
            o.pll     = 1'b0;
            o.sel_rc  = 1'b1;
            o.mode    = MODE_DEEP;
         end
         ST_STBY: begin
            o.cpu_clk = 1'b0;
            o.bus_clk = 1'b0;
            o.rcosc   = 1'b0;
            o.xtal    = 1'b0;
            o.pll     = 1'b0;
            o.reg_off = 1'b1;
            o.pwr_on  = 1'b0;
            o.mode    = MODE_STBY;
         end
         ST_PORH: begin
            o.cpu_clk = 1'b0;
            o.bus_clk = 1'b0;
            o.xtal    = 1'b0;
            o.pll     = 1'b0;
            o.sel_rc  = 1'b1;
            o.por     = 1'b1;
            o.mode    = MODE_STBY;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int LINES       = 8,
   parameter int EXIT_NORM   = 4,
   parameter int EXIT_LP     = 12,
   parameter int POR_HOLD    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wfi_req,
   input  logic             wfe_req,
   input  logic             isr_exit,
   input  logic             deep_sel,
   input  logic             stby_sel,
   input  logic             exit_sleep_sel,
   input  logic             lp_reg_sel,
   input  logic             sev_pend_sel,
   input  logic [LINES-1:0] line_irq,
   input  logic [LINES-1:0] line_evt,
   input  logic [LINES-1:0] line_pend,
   input  logic             ext_rst,
   input  logic             rtc_alarm,
   input  logic             wdog_rst,
   input  logic             wake_pin,
   input  logic             clr_stby,
   input  logic             clr_wake,
   output logic             cpu_clk_en,
   output logic             bus_clk_en,
   output logic             rcosc_en,
   output logic             xtal_en,
   output logic             pll_en,
   output logic             reg_lp,
   output logic             reg_off,
   output logic             core_pwr_on,
   output logic             clk_sel_rc,
   output logic             por_req,
   output logic [1:0]       mode,
   output logic             stby_flag,
   output logic             wake_flag
);

   localparam int MAXLOAD = (EXIT_LP > POR_HOLD) ? EXIT_LP : POR_HOLD;
   localparam int CW      = (MAXLOAD < 1) ? 1 : $clog2(MAXLOAD + 1);

   initial begin : p_param_chk
      assert (LINES >= 1)            else $fatal(1, "LINES must be at least 1");
      assert (SYNC_STAGES >= 2)      else $fatal(1, "SYNC_STAGES must be at least 2");
      assert (EXIT_NORM >= 0)        else $fatal(1, "EXIT_NORM must not be negative");
      assert (EXIT_LP >= EXIT_NORM)  else $fatal(1, "EXIT_LP must not be below EXIT_NORM");
      assert (POR_HOLD >= 0)         else $fatal(1, "POR_HOLD must not be negative");
   end

   lpm_state_e    state_q, state_d;
   logic          via_wfe_q;
   logic          lp_q;
   logic          stby_flag_q;
   logic          wake_flag_q;
   logic          pin_rise;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_zero;
   lpm_out_t      dec;

   // request classification
   logic req_any, req_wfe, light_go, light_wfe, deep_go, stby_go;
   logic any_irq, any_evt, any_pend, line_wake, stby_wake;

   assign req_any   = wfi_req | wfe_req;
   assign req_wfe   = wfe_req & ~wfi_req;
   assign light_go  = ~deep_sel & (exit_sleep_sel ? isr_exit : req_any);
   assign light_wfe = ~exit_sleep_sel & req_wfe;
   assign any_irq   = |line_irq;
   assign any_evt   = |line_evt;
   assign any_pend  = |line_pend;
   assign deep_go   = deep_sel & ~stby_sel & req_any & ~any_pend;
   assign stby_go   = deep_sel & stby_sel & req_any & ~wake_flag_q;
   assign line_wake = via_wfe_q ? (any_evt | (sev_pend_sel & any_irq)) : any_irq;
   assign stby_wake = ext_rst | rtc_alarm | wdog_rst | pin_rise;

   lpm_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (wake_pin),
      .rise (pin_rise)
   );

   lpm_dncnt #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .zero    (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_RUN: begin
            if (stby_go)       state_d = ST_STBY;
            else if (deep_go)  state_d = ST_DEEP;
            else if (light_go) state_d = ST_SLEEP;
         end
         ST_SLEEP: if (line_wake) state_d = ST_RUN;
         ST_DEEP: begin
            if (line_wake) begin
               state_d  = ST_DEXIT;
               tmr_load = 1'b1;
               tmr_val  = lp_q ? CW'(EXIT_LP) : CW'(EXIT_NORM);
            end
         end
         ST_DEXIT: if (tmr_zero) state_d = ST_RUN;
         ST_STBY: begin
            if (stby_wake) begin
               state_d  = ST_PORH;
               tmr_load = 1'b1;
               tmr_val  = CW'(POR_HOLD);
            end
         end
         ST_PORH: if (tmr_zero) state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_RUN;
         via_wfe_q   <= 1'b0;
         lp_q        <= 1'b0;
         stby_flag_q <= 1'b0;
         wake_flag_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RUN) begin
            via_wfe_q <= deep_sel ? req_wfe : light_wfe;
            lp_q      <= lp_reg_sel;
         end
         if (state_q == ST_RUN && state_d == ST_STBY) stby_flag_q <= 1'b1;
         else if (clr_stby)                           stby_flag_q <= 1'b0;
         if (pin_rise)      wake_flag_q <= 1'b1;
         else if (clr_wake) wake_flag_q <= 1'b0;
      end
   end

   lpm_out_dec u_dec (
      .state  (state_q),
      .lp_hold(lp_q),
      .o      (dec)
   );

   assign cpu_clk_en  = dec.cpu_clk;
   assign bus_clk_en  = dec.bus_clk;
   assign rcosc_en    = dec.rcosc;
   assign xtal_en     = dec.xtal;
   assign pll_en      = dec.pll;
   assign reg_lp      = dec.reg_lp;
   assign reg_off     = dec.reg_off;
   assign core_pwr_on = dec.pwr_on;
   assign clk_sel_rc  = dec.sel_rc;
   assign por_req     = dec.por;
   assign mode        = dec.mode;
   assign stby_flag   = stby_flag_q;
   assign wake_flag   = wake_flag_q;

   AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && !any_irq && !any_evt) |=> state_q == ST_SLEEP); // R4

   AST_EXIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEXIT && !tmr_zero) |=> state_q == ST_DEXIT); // R6

   AST_PEND_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && req_any && deep_sel && !stby_sel && any_pend)
      |=> state_q == ST_RUN); // R7

   AST_STBY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STBY) |-> stby_flag_q); // R8

   AST_STBY_TO_POR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STBY && stby_wake) |=> state_q == ST_PORH); // R9

   AST_STBY_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PORH && !clr_stby) |=> stby_flag_q); // R11

endmodule

// File: tb/sim_lpm_seq.sv
`timescale 1ns/1ps
module sim_lpm_seq;

   localparam int LINES     = 8;
   localparam int EXIT_NORM = 4;
   localparam int EXIT_LP   = 12;
   localparam int POR_HOLD  = 6;

   localparam int S_RUN = 0, S_SLEEP = 1, S_DEEP = 2, S_DEXIT = 3, S_STBY = 4, S_PORH = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi_req = 0, wfe_req = 0, isr_exit = 0;
   logic deep_sel = 0, stby_sel = 0, exit_sleep_sel = 0, lp_reg_sel = 0, sev_pend_sel = 0;
   logic [LINES-1:0] line_irq = '0, line_evt = '0, line_pend = '0;
   logic ext_rst = 0, rtc_alarm = 0, wdog_rst = 0, wake_pin = 0, clr_stby = 0, clr_wake = 0;
   logic cpu_clk_en, bus_clk_en, rcosc_en, xtal_en, pll_en, reg_lp, reg_off;
   logic core_pwr_on, clk_sel_rc, por_req, stby_flag, wake_flag;
   logic [1:0] mode;

   always #5 clk = ~clk;

   lpm_seq #(.LINES(LINES), .EXIT_NORM(EXIT_NORM), .EXIT_LP(EXIT_LP),
             .POR_HOLD(POR_HOLD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req), .isr_exit(isr_exit),
      .deep_sel(deep_sel), .stby_sel(stby_sel), .exit_sleep_sel(exit_sleep_sel),
      .lp_reg_sel(lp_reg_sel), .sev_pend_sel(sev_pend_sel),
      .line_irq(line_irq), .line_evt(line_evt), .line_pend(line_pend),
      .ext_rst(ext_rst), .rtc_alarm(rtc_alarm), .wdog_rst(wdog_rst), .wake_pin(wake_pin),
      .clr_stby(clr_stby), .clr_wake(clr_wake),
      .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .rcosc_en(rcosc_en),
      .xtal_en(xtal_en), .pll_en(pll_en), .reg_lp(reg_lp), .reg_off(reg_off),
      .core_pwr_on(core_pwr_on), .clk_sel_rc(clk_sel_rc), .por_req(por_req),
      .mode(mode), .stby_flag(stby_flag), .wake_flag(wake_flag)
   );

   // observed vector: {cpu,bus,rc,xtal,pll,reg_lp,reg_off,pwr,sel_rc,por,mode,stby,wake}
   logic [13:0] obs;
   assign obs = {cpu_clk_en, bus_clk_en, rcosc_en, xtal_en, pll_en, reg_lp, reg_off,
                 core_pwr_on, clk_sel_rc, por_req, mode, stby_flag, wake_flag};

   typedef struct {
      string       tag;
      logic [13:0] exp;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   logic  exp_stby = 0;
   logic  exp_wake = 0;
   bit    finished = 0;

   // expected outputs per level, taken from the requirement text
   function automatic logic [13:0] ev(input int st, input logic lp);
      logic [9:0] b;
      logic [1:0] m;
      case (st)
         S_SLEEP: begin b = 10'b0111100100; m = 2'd1; end
         S_DEEP:  begin b = {5'b00000, lp, 4'b0100}; m = 2'd2; end
         S_DEXIT: begin b = 10'b0010000110; m = 2'd2; end
         S_STBY:  begin b = 10'b0000001000; m = 2'd3; end
         S_PORH:  begin b = 10'b0010000111; m = 2'd3; end
         default: begin b = 10'b1111100100; m = 2'd0; end
      endcase
      return {b, m, exp_stby, exp_wake};
   endfunction

   // driver: one clock step, clears strobes, queues the expectation
   task automatic cyc(input string tag, input int st, input logic lp);
      @(posedge clk); #1;
      wfi_req = 0; wfe_req = 0; isr_exit = 0; clr_stby = 0; clr_wake = 0;
      ext_rst = 0; rtc_alarm = 0; wdog_rst = 0;
      sb_q.push_back('{tag, ev(st, lp)});
      @(negedge clk); #1;
   endtask

   // monitor: pops and compares away from the active edge
   always @(negedge clk) begin : mon
      item_t it;
      if (sb_q.size() != 0) begin
         it = sb_q.pop_front();
         n_chk++;
         if (obs !== it.exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", it.tag, obs, it.exp);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   // one Standby round with a chosen wake source (0 reset pin, 1 alarm, 2 watchdog)
   task automatic stby_round(input int src);
      deep_sel = 1; stby_sel = 1; wfe_req = 1;
      exp_stby = 1;
      cyc("R8 enter standby", S_STBY, 0);
      line_irq = 8'hFF; line_evt = 8'hFF;
      cyc("R9 line activity ignored in standby", S_STBY, 0);
      line_irq = '0; line_evt = '0;
      case (src)
         0: ext_rst = 1;
         1: rtc_alarm = 1;
         default: wdog_rst = 1;
      endcase
      cyc("R9 wake starts reset hold", S_PORH, 0);
      for (int i = 0; i < POR_HOLD; i++) cyc("R9 reset hold", S_PORH, 0);
      cyc("R11 run after hold keeps stby flag", S_RUN, 0);
      clr_stby = 1; exp_stby = 0;
      cyc("R11 stby flag cleared", S_RUN, 0);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      cyc("R1 reset state", S_RUN, 0);

      // R2 sleep-now
      isr_exit = 1;
      cyc("R2 handler return ignored", S_RUN, 0);
      wfi_req = 1;
      cyc("R2 wfi enters sleep", S_SLEEP, 0);
      line_evt = 8'h10;
      cyc("R4 event does not wake wfi sleep", S_SLEEP, 0);
      line_evt = '0; line_irq = 8'h08;
      cyc("R4 interrupt wakes wfi sleep", S_RUN, 0);
      line_irq = '0;
      wfe_req = 1;
      cyc("R2 wfe enters sleep", S_SLEEP, 0);
      line_irq = 8'h01;
      cyc("R4 interrupt ignored without set-on-pending", S_SLEEP, 0);
      sev_pend_sel = 1;
      cyc("R4 interrupt wakes with set-on-pending", S_RUN, 0);
      line_irq = '0; sev_pend_sel = 0;
      wfe_req = 1;
      cyc("R2 wfe enters sleep again", S_SLEEP, 0);
      line_evt = 8'h80;
      cyc("R4 event wakes wfe sleep", S_RUN, 0);
      line_evt = '0;

      // R3 sleep-on-exit
      exit_sleep_sel = 1; wfi_req = 1;
      cyc("R3 wfi ignored with sleep-on-exit", S_RUN, 0);
      wfe_req = 1;
      cyc("R3 wfe ignored with sleep-on-exit", S_RUN, 0);
      isr_exit = 1;
      cyc("R3 handler return enters sleep", S_SLEEP, 0);
      line_evt = 8'h02;
      cyc("R3 handler-return sleep ignores event", S_SLEEP, 0);
      line_evt = '0; line_irq = 8'h40;
      cyc("R3 handler-return sleep wakes on interrupt", S_RUN, 0);
      line_irq = '0; exit_sleep_sel = 0;

      // R7 pending abort
      deep_sel = 1; line_pend = 8'h20; wfi_req = 1;
      cyc("R7 pending line blocks deep-sleep", S_RUN, 0);
      line_pend = '0;

      // R5 / R6 deep-sleep, regulator normal
      lp_reg_sel = 0; wfi_req = 1;
      cyc("R5 enter deep-sleep", S_DEEP, 0);
      line_evt = 8'h04;
      cyc("R4 event ignored in wfi deep-sleep", S_DEEP, 0);
      line_evt = '0; line_irq = 8'h04;
      cyc("R6 exit starts", S_DEXIT, 0);
      line_irq = '0;
      for (int i = 0; i < EXIT_NORM; i++) cyc("R6 normal exit wait", S_DEXIT, 0);
      cyc("R6 normal exit done", S_RUN, 0);

      // R5 / R6 deep-sleep, regulator low-power, via wfe
      lp_reg_sel = 1; wfe_req = 1;
      cyc("R5 deep-sleep low-power regulator", S_DEEP, 1);
      lp_reg_sel = 0;
      cyc("R5 regulator mode held", S_DEEP, 1);
      line_irq = 8'h01;
      cyc("R4 interrupt ignored in wfe deep-sleep", S_DEEP, 1);
      line_irq = '0; line_evt = 8'h01;
      cyc("R6 low-power exit starts", S_DEXIT, 0);
      line_evt = '0;
      for (int i = 0; i < EXIT_LP; i++) cyc("R6 low-power exit wait", S_DEXIT, 0);
      cyc("R6 low-power exit done", S_RUN, 0);

      // R8 / R9 / R11 standby from each timed source
      stby_round(0);
      stby_round(1);
      stby_round(2);

      // R10 wake pin and flag
      deep_sel = 1; stby_sel = 1;
      wake_pin = 1;
      cyc("R10 pin in first flop", S_RUN, 0);
      cyc("R10 pin in second flop", S_RUN, 0);
      exp_wake = 1;
      cyc("R10 wake flag set", S_RUN, 0);
      wfi_req = 1;
      cyc("R8 standby refused with wake flag", S_RUN, 0);
      clr_wake = 1; exp_wake = 0;
      cyc("R11 wake flag cleared", S_RUN, 0);
      wfi_req = 1; exp_stby = 1;
      cyc("R8 standby entered with pin high", S_STBY, 0);
      for (int i = 0; i < 4; i++) cyc("R10 held pin does not wake", S_STBY, 0);
      wake_pin = 0;
      for (int i = 0; i < 3; i++) cyc("R10 falling pin does not wake", S_STBY, 0);
      wake_pin = 1;
      cyc("R10 rise in sync first", S_STBY, 0);
      cyc("R10 rise in sync second", S_STBY, 0);
      exp_wake = 1;
      cyc("R10 pin rise wakes standby", S_PORH, 0);
      for (int i = 0; i < POR_HOLD; i++) cyc("R9 reset hold after pin", S_PORH, 0);
      cyc("R11 both flags kept after hold", S_RUN, 0);
      clr_stby = 1; clr_wake = 1; exp_stby = 0; exp_wake = 0;
      cyc("R11 both flags cleared", S_RUN, 0);

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule